// File: doc/BRIEF.md
# BMC-side block-transfer mailbox register window

This block is the management-controller face of an IPMI block-transfer mailbox. Firmware reaches it through a small register bus of seven 32-bit words at byte offsets 0x00 to 0x18. The window holds a handshake/control register, a byte-wide data port and an interrupt enable/status pair. Three further words are plain storage: a configuration word, a spare word and a mask word. The block drives one interrupt line.

An upstream receive deframer owns the inbound message bytes. It announces a finished message with a one-cycle `msg_ready` pulse and presents the message length. The block fetches inbound bytes from it by index. Outbound bytes that firmware pushes through the data port are handed to an external buffer as indexed byte writes. When firmware requests transmission, `send_req` pulses so that the transport can ship the buffer.

Firmware uses the control register for one action per write. Its actions are pointer clears, acknowledging host attention, toggling its own busy flag and requesting transmission. When the busy flag is clear after a control write, the deframer is told to drop its inbound state.

Top module: `bt_bmc_regs`

## Requirements
- R1: After reset the control and status registers read 0, `irq`, `in_waiting`, `send_req` and `out_len` are 0, and the first data-port read returns `in_len`.
- R2: The words at 0x00, 0x04, 0x0C and 0x18 store the full 32-bit written value and read it back. Offset 0x1C reads 0, and a write to it changes no other register.
- R3: A write to the control register (0x10) performs exactly one action, chosen by the first set bit in this order: bit0 clear-write-pointer, bit1 clear-read-pointer, bit2 acknowledge host attention, bit7 toggle busy, bit3 send. A write with none of these bits set performs no action and pulses `ctrl_unexp` for one cycle after the write edge.
- R4: A `msg_ready` pulse sets control bit2 (host attention). A control write whose selected action is bit2 clears it.
- R5: A control write whose selected action is bit7 toggles control bit7 (BMC busy).
- R6: A control write whose selected action is bit3 makes control bits 3 and 6 read as 1 and `send_req` high for exactly the next cycle. All three are low afterwards.
- R7: After a clear-read-pointer action (or reset), the first data-port (0x14) read returns `in_len`. Each later read returns inbound byte 0, 1, … fetched at index `in_idx`, until `in_len` bytes have been read. Reads past the end return 0.
- R8: A data-port write stores its low byte at index `out_len` and increments `out_len`, but only while `out_len` is below 64. The clear-write-pointer action sets `out_len` to 0.
- R9: While host attention is set and enable bit0 is set, status bit0, `in_waiting` and `irq` are set. While control bit6 is set and enable bit6 is set, status bit6 and `irq` are set.
- R10: A status-register (0x08) write clears the written status bits and drops `irq`, except that a set condition still holding in that cycle wins.
- R11: A control write that leaves bit7 clear pulses `in_release` for one cycle after the write edge and clears `in_waiting`. A control write that leaves bit7 set does neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (data-port reads advance the pointer) |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while `bus_rd` is high |
| msg_ready | input | 1 | Deframer finished an inbound message |
| in_len | input | LEN_W | Inbound message length |
| in_byte | input | 8 | Inbound byte at `in_idx` |
| in_idx | output | IDX_W | Inbound byte index |
| in_waiting | output | 1 | Inbound message waits for firmware |
| in_release | output | 1 | Pulse: deframer drops its inbound state |
| out_we | output | 1 | Outbound byte write |
| out_idx | output | IDX_W | Outbound byte index |
| out_data | output | 8 | Outbound byte |
| out_len | output | LEN_W | Outbound byte count |
| send_req | output | 1 | Pulse: transmit the outbound buffer |
| ctrl_unexp | output | 1 | Pulse: control write matched no action |
| irq | output | 1 | Interrupt line |

## Verification
The bench sweeps all 256 control-write values and predicts the single selected action. A design with a wrong priority would, for example, toggle busy on a value that also asks for a pointer clear, or flag a valid value as unexpected. The data port is run with zero-length, short and full 64-byte inbound messages. An off-by-one read index would return a stale byte or miss the trailing zero. The outbound side is overfilled past 64 bytes, so a missing bound would wrap the index and overwrite byte 0. Status clearing is tried both while its set condition still holds and after it has gone. Release is tried with busy left set and left clear, so a design that releases unconditionally or drops an interrupt too early is exposed.

// File: rtl/bt_pkg.sv
package bt_pkg;
  // word indices (byte offset >> 2)
  localparam int WI_CFG   = 0;
  localparam int WI_IEN   = 1;
  localparam int WI_STAT  = 2;
  localparam int WI_SPARE = 3;
  localparam int WI_CTRL  = 4;
  localparam int WI_DATA  = 5;
  localparam int WI_MASK  = 6;
  localparam int NUM_WORDS = 7;

  // control bit positions
  localparam int CB_CLR_WR = 0;
  localparam int CB_CLR_RD = 1;
  localparam int CB_H2B    = 2;
  localparam int CB_B2H    = 3;
  localparam int CB_H_BUSY = 6;
  localparam int CB_B_BUSY = 7;

  // interrupt enable / status bit positions
  localparam int IB_H2B   = 0;
  localparam int IB_HBUSY = 6;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_CLR_WR, ACT_CLR_RD, ACT_H2B, ACT_BBUSY, ACT_B2H
  } act_e;

  function automatic act_e pick_act(input logic [7:0] v);
    if (v[CB_CLR_WR])      return ACT_CLR_WR;
    else if (v[CB_CLR_RD]) return ACT_CLR_RD;
    else if (v[CB_H2B])    return ACT_H2B;
    else if (v[CB_B_BUSY]) return ACT_BBUSY;
    else if (v[CB_B2H])    return ACT_B2H;
    else                   return ACT_NONE;
  endfunction
endpackage

// File: rtl/bt_ctrl_hs.sv
module bt_ctrl_hs
  import bt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       msg_ready,
  output act_e       act,
  output logic       b_busy,
  output logic       send_pulse,
  output logic       h2b_atn,
  output logic       release_now,
  output logic       release_q,
  output logic       unexp_q
);
  logic bb_q, bb_d, pulse_q, pulse_d, h2b_q, h2b_d, rel_q, rel_d, unx_q, unx_d;

  always_comb begin
    act     = ctrl_we ? pick_act(ctrl_wdata) : ACT_NONE;
    bb_d    = (act == ACT_BBUSY) ? ~bb_q : bb_q;
    pulse_d = (act == ACT_B2H);
    if (msg_ready)            h2b_d = 1'b1;
    else if (act == ACT_H2B)  h2b_d = 1'b0;
    else                      h2b_d = h2b_q;
    release_now = ctrl_we & ~bb_d;
    rel_d   = release_now;
    unx_d   = ctrl_we & (act == ACT_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bb_q    <= 1'b0;
      pulse_q <= 1'b0;
      h2b_q   <= 1'b0;
      rel_q   <= 1'b0;
      unx_q   <= 1'b0;
    end else begin
      bb_q    <= bb_d;
      pulse_q <= pulse_d;
      h2b_q   <= h2b_d;
      rel_q   <= rel_d;
      unx_q   <= unx_d;
    end
  end

  assign b_busy     = bb_q;
  assign send_pulse = pulse_q;
  assign h2b_atn    = h2b_q;
  assign release_q  = rel_q;
  assign unexp_q    = unx_q;
endmodule

// File: rtl/bt_data_port.sv
module bt_data_port #(
  parameter int BUF_DEPTH = 64,
  parameter int LEN_W     = $clog2(BUF_DEPTH + 1),
  parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_wr,
  input  logic             clr_rd,
  input  logic             dp_rd,
  input  logic             dp_we,
  input  logic [7:0]       wbyte,
  input  logic [LEN_W-1:0] in_len,
  input  logic [7:0]       in_byte,
  output logic [7:0]       rd_byte,
  output logic [IDX_W-1:0] in_idx,
  output logic             out_we,
  output logic [IDX_W-1:0] out_idx,
  output logic [7:0]       out_data,
  output logic [LEN_W-1:0] out_len
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(BUF_DEPTH);

  logic             pend_q, pend_d;
  logic [LEN_W-1:0] ridx_q, ridx_d, olen_q, olen_d;
  logic             in_range;

  always_comb begin
    in_range = (ridx_q < in_len);
    if (pend_q)        rd_byte = 8'(in_len);
    else if (in_range) rd_byte = in_byte;
    else               rd_byte = 8'h00;

    pend_d = pend_q;
    ridx_d = ridx_q;
    if (clr_rd) begin
      pend_d = 1'b1;
      ridx_d = '0;
    end else if (dp_rd) begin
      if (pend_q) begin
        pend_d = 1'b0;
        ridx_d = '0;
      end else if (in_range) begin
        ridx_d = ridx_q + 1'b1;
      end
    end

    out_we = dp_we & (olen_q < FULL);
    if (clr_wr)      olen_d = '0;
    else if (out_we) olen_d = olen_q + 1'b1;
    else             olen_d = olen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      ridx_q <= '0;
      olen_q <= '0;
    end else begin
      pend_q <= pend_d;
      ridx_q <= ridx_d;
      olen_q <= olen_d;
    end
  end

  assign in_idx   = ridx_q[IDX_W-1:0];
  assign out_idx  = olen_q[IDX_W-1:0];
  assign out_data = wbyte;
  assign out_len  = olen_q;
endmodule

// File: rtl/bt_irq.sv
module bt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en_h2b,
  input  logic en_hbusy,
  input  logic h2b_atn,
  input  logic h_busy,
  input  logic stat_we,
  input  logic clr_h2b,
  input  logic clr_hbusy,
  input  logic release_now,
  output logic st_h2b,
  output logic st_hbusy,
  output logic irq,
  output logic waiting
);
  logic set_h2b, set_hb;
  logic s0_q, s0_d, s6_q, s6_d, irq_q, irq_d, w_q, w_d;

  always_comb begin
    set_h2b = h2b_atn & en_h2b;
    set_hb  = h_busy & en_hbusy;
    s0_d    = set_h2b | (s0_q & ~(stat_we & clr_h2b));
    s6_d    = set_hb  | (s6_q & ~(stat_we & clr_hbusy));
    if (set_h2b | set_hb) irq_d = 1'b1;
    else if (stat_we)     irq_d = 1'b0;
    else                  irq_d = irq_q;
    if (release_now)      w_d = 1'b0;
    else if (set_h2b)     w_d = 1'b1;
    else                  w_d = w_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q  <= 1'b0;
      s6_q  <= 1'b0;
      irq_q <= 1'b0;
      w_q   <= 1'b0;
    end else begin
      s0_q  <= s0_d;
      s6_q  <= s6_d;
      irq_q <= irq_d;
      w_q   <= w_d;
    end
  end

  assign st_h2b   = s0_q;
  assign st_hbusy = s6_q;
  assign irq      = irq_q;
  assign waiting  = w_q;
endmodule

// File: rtl/bt_bmc_regs.sv
module bt_bmc_regs
  import bt_pkg::*;
#(
  parameter int  ADDR_W    = 5,
  parameter int  DATA_W    = 32,
  parameter int  BUF_DEPTH = 64,
  localparam int LEN_W     = $clog2(BUF_DEPTH + 1),
  localparam int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              msg_ready,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [7:0]        in_byte,
  output logic [IDX_W-1:0]  in_idx,
  output logic              in_waiting,
  output logic              in_release,
  output logic              out_we,
  output logic [IDX_W-1:0]  out_idx,
  output logic [7:0]        out_data,
  output logic [LEN_W-1:0]  out_len,
  output logic              send_req,
  output logic              ctrl_unexp,
  output logic              irq
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              hit;
  logic              sel_cfg, sel_ien, sel_stat, sel_spare, sel_ctrl, sel_data, sel_mask;

  assign widx      = bus_addr[ADDR_W-1:2];
  assign hit       = (widx < WIDX_W'(NUM_WORDS));
  assign sel_cfg   = hit && (widx == WIDX_W'(WI_CFG));
  assign sel_ien   = hit && (widx == WIDX_W'(WI_IEN));
  assign sel_stat  = hit && (widx == WIDX_W'(WI_STAT));
  assign sel_spare = hit && (widx == WIDX_W'(WI_SPARE));
  assign sel_ctrl  = hit && (widx == WIDX_W'(WI_CTRL));
  assign sel_data  = hit && (widx == WIDX_W'(WI_DATA));
  assign sel_mask  = hit && (widx == WIDX_W'(WI_MASK));

  // plain storage words
  logic [DATA_W-1:0] cfg_q, cfg_d, ien_q, ien_d, spare_q, spare_d, mask_q, mask_d;

  always_comb begin
    cfg_d   = (bus_wr && sel_cfg)   ? bus_wdata : cfg_q;
    ien_d   = (bus_wr && sel_ien)   ? bus_wdata : ien_q;
    spare_d = (bus_wr && sel_spare) ? bus_wdata : spare_q;
    mask_d  = (bus_wr && sel_mask)  ? bus_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ien_q   <= '0;
      spare_q <= '0;
      mask_q  <= '0;
    end else begin
      cfg_q   <= cfg_d;
      ien_q   <= ien_d;
      spare_q <= spare_d;
      mask_q  <= mask_d;
    end
  end

  // handshake
  act_e act;
  logic b_busy, hs_pulse, h2b_atn, release_now;

  bt_ctrl_hs u_hs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (bus_wr && sel_ctrl),
    .ctrl_wdata  (bus_wdata[7:0]),
    .msg_ready   (msg_ready),
    .act         (act),
    .b_busy      (b_busy),
    .send_pulse  (hs_pulse),
    .h2b_atn     (h2b_atn),
    .release_now (release_now),
    .release_q   (in_release),
    .unexp_q     (ctrl_unexp)
  );

  assign send_req = hs_pulse;

  // data port
  logic [7:0] dp_byte;

  bt_data_port #(.BUF_DEPTH(BUF_DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_wr   (act == ACT_CLR_WR),
    .clr_rd   (act == ACT_CLR_RD),
    .dp_rd    (bus_rd && sel_data),
    .dp_we    (bus_wr && sel_data),
    .wbyte    (bus_wdata[7:0]),
    .in_len   (in_len),
    .in_byte  (in_byte),
    .rd_byte  (dp_byte),
    .in_idx   (in_idx),
    .out_we   (out_we),
    .out_idx  (out_idx),
    .out_data (out_data),
    .out_len  (out_len)
  );

  // interrupts
  logic st_h2b, st_hbusy;

  bt_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_h2b      (ien_q[IB_H2B]),
    .en_hbusy    (ien_q[IB_HBUSY]),
    .h2b_atn     (h2b_atn),
    .h_busy      (hs_pulse),
    .stat_we     (bus_wr && sel_stat),
    .clr_h2b     (bus_wdata[IB_H2B]),
    .clr_hbusy   (bus_wdata[IB_HBUSY]),
    .release_now (release_now),
    .st_h2b      (st_h2b),
    .st_hbusy    (st_hbusy),
    .irq         (irq),
    .waiting     (in_waiting)
  );

  // read mux
  logic [DATA_W-1:0] ctrl_word, stat_word;

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[CB_B_BUSY] = b_busy;
    ctrl_word[CB_H_BUSY] = hs_pulse;
    ctrl_word[CB_B2H]    = hs_pulse;
    ctrl_word[CB_H2B]    = h2b_atn;
    stat_word            = '0;
    stat_word[IB_H2B]    = st_h2b;
    stat_word[IB_HBUSY]  = st_hbusy;

    bus_rdata = '0;
    if (sel_cfg)   bus_rdata = cfg_q;
    if (sel_ien)   bus_rdata = ien_q;
    if (sel_stat)  bus_rdata = stat_word;
    if (sel_spare) bus_rdata = spare_q;
    if (sel_ctrl)  bus_rdata = ctrl_word;
    if (sel_data)  bus_rdata = DATA_W'(dp_byte);
    if (sel_mask)  bus_rdata = mask_q;
  end
endmodule

// File: rtl/bt_bmc_regs_chk.sv
module bt_bmc_regs_chk #(
  parameter int BUF_DEPTH = 64,
  parameter int LEN_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             out_we,
  input logic [LEN_W-1:0] out_len,
  input logic             send_req,
  input logic             in_release,
  input logic             in_waiting,
  input logic             irq,
  input logic             st_any
);
  AST_OUT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_len <= LEN_W'(BUF_DEPTH)); // R8

  AST_OUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |=> (out_len == $past(out_len) + 1'b1)); // R8

  AST_SEND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (send_req && !bus_wr) |=> !send_req); // R6

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> st_any); // R9

  AST_RELEASE_CLEARS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_release |-> !in_waiting); // R11
endmodule

bind bt_bmc_regs bt_bmc_regs_chk #(.BUF_DEPTH(BUF_DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .out_we     (out_we),
  .out_len    (out_len),
  .send_req   (send_req),
  .in_release (in_release),
  .in_waiting (in_waiting),
  .irq        (irq),
  .st_any     (st_h2b | st_hbusy)
);

// File: tb/sim_bt_bmc_regs.sv
module sim_bt_bmc_regs;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        msg_ready = 1'b0;
  logic [6:0]  in_len = '0;
  logic [7:0]  in_byte;
  logic [5:0]  in_idx;
  logic        in_waiting, in_release, out_we, send_req, ctrl_unexp, irq;
  logic [5:0]  out_idx;
  logic [7:0]  out_data;
  logic [6:0]  out_len;

  logic [7:0]  in_mem  [DEPTH];
  logic [7:0]  cap_mem [DEPTH];
  int          cap_cnt = 0;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign in_byte = in_mem[in_idx];

  always @(posedge clk) if (out_we) begin
    cap_mem[out_idx] <= out_data;
    cap_cnt <= cap_cnt + 1;
  end

  bt_bmc_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msg_ready(msg_ready), .in_len(in_len), .in_byte(in_byte), .in_idx(in_idx),
    .in_waiting(in_waiting), .in_release(in_release), .out_we(out_we),
    .out_idx(out_idx), .out_data(out_data), .out_len(out_len),
    .send_req(send_req), .ctrl_unexp(ctrl_unexp), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic pulse_msg();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < DEPTH; i++) in_mem[i] = 8'((i * 37 + 11) & 8'hFF);
    in_len = 7'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();

    // R1 reset state
    rd(5'h10, v); check(v == 0, "R1 ctrl", v, 0);
    rd(5'h08, v); check(v == 0, "R1 status", v, 0);
    check(irq == 0 && in_waiting == 0 && send_req == 0, "R1 outputs", {irq, in_waiting, send_req}, 0);
    check(out_len == 0, "R1 out_len", 32'(out_len), 0);
    rd(5'h14, v); check(v == 3, "R1 first data read", v, 3);

    // R2 storage words and unmapped offset
    begin
      logic [4:0] offs [4] = '{5'h00, 5'h04, 5'h0C, 5'h18};
      for (int k = 0; k < 4; k++) begin
        logic [31:0] pat;
        pat = 32'hA5C3_0000 ^ (32'(k) * 32'h0101_1357);
        wr(offs[k], pat);
        rd(offs[k], v); check(v == pat, "R2 readback", v, pat);
      end
      wr(5'h1C, 32'hFFFF_FFFF);
      rd(5'h1C, v); check(v == 0, "R2 unmapped read", v, 0);
      rd(5'h00, v); check(v == 32'hA5C3_0000, "R2 unmapped write no effect", v, 32'hA5C3_0000);
      for (int k = 0; k < 4; k++) wr(offs[k], 32'h0);
    end

    // R3 R4 R5 R6 priority sweep over every control value
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cv;
      int a;
      logic [31:0] ex;
      cv = 8'(c);
      if (cv[0]) a = 1; else if (cv[1]) a = 2; else if (cv[2]) a = 3;
      else if (cv[7]) a = 4; else if (cv[3]) a = 5; else a = 0;
      pulse_msg();
      wr(5'h10, 32'(cv));
      check(ctrl_unexp == (a == 0), "R3 unexpected flag", 32'(ctrl_unexp), 32'(a == 0));
      check(send_req == (a == 5), "R6 send pulse", 32'(send_req), 32'(a == 5));
      ex = 0;
      if (a == 4) ex[7] = 1'b1;
      if (a == 5) begin ex[6] = 1'b1; ex[3] = 1'b1; end
      if (a != 3) ex[2] = 1'b1;
      rd(5'h10, v);
      check(v == ex, "R3 R4 R5 R6 ctrl after action", v, ex);
      if (a == 4) wr(5'h10, 32'h80);
    end
    rd(5'h10, v); check(v == 32'h04, "R6 send bits gone", v, 32'h04);
    check(send_req == 0, "R6 send low after", 32'(send_req), 0);
    wr(5'h10, 32'h04);

    // R7 data-port reads for several lengths
    begin
      int lens [3] = '{0, 5, 64};
      for (int t = 0; t < 3; t++) begin
        in_len = 7'(lens[t]);
        wr(5'h10, 32'h02);
        rd(5'h14, v); check(v == 32'(lens[t]), "R7 length first", v, 32'(lens[t]));
        for (int i = 0; i < lens[t]; i++) begin
          rd(5'h14, v); check(v == 32'(in_mem[i]), "R7 byte", v, 32'(in_mem[i]));
        end
        rd(5'h14, v); check(v == 0, "R7 past end", v, 0);
      end
    end

    // R8 outbound fill with overflow
    wr(5'h10, 32'h01);
    check(out_len == 0, "R8 clear write ptr", 32'(out_len), 0);
    cap_cnt = 0;
    for (int i = 0; i < 70; i++) wr(5'h14, 32'h1200 | 32'((i ^ 8'h5A) & 8'hFF));
    check(out_len == 64, "R8 length capped", 32'(out_len), 64);
    check(cap_cnt == 64, "R8 write count", 32'(cap_cnt), 64);
    for (int i = 0; i < DEPTH; i++)
      check(cap_mem[i] == 8'(i ^ 8'h5A), "R8 stored byte", 32'(cap_mem[i]), 32'(i ^ 8'h5A));
    wr(5'h10, 32'h01);
    check(out_len == 0, "R8 cleared again", 32'(out_len), 0);

    // R9 R10 R11 host-attention interrupt
    wr(5'h04, 32'h41);
    pulse_msg();
    idle();
    check(irq == 1 && in_waiting == 1, "R9 h2b irq and waiting", {irq, in_waiting}, 2'b11);
    rd(5'h08, v); check(v == 32'h01, "R9 status bit0", v, 1);
    wr(5'h08, 32'h01);
    check(irq == 1, "R10 set wins over clear", 32'(irq), 1);
    wr(5'h10, 32'h04);
    check(in_waiting == 0 && in_release == 1, "R11 release clears waiting", {in_waiting, in_release}, 2'b01);
    wr(5'h08, 32'h01);
    check(irq == 0, "R10 irq dropped", 32'(irq), 0);
    rd(5'h08, v); check(v == 0, "R10 status cleared", v, 0);

    // R9 R10 host-busy interrupt
    wr(5'h10, 32'h08);
    check(send_req == 1, "R6 send", 32'(send_req), 1);
    idle();
    check(irq == 1 && send_req == 0, "R9 hbusy irq", {irq, send_req}, 2'b10);
    rd(5'h08, v); check(v == 32'h40, "R9 status bit6", v, 32'h40);
    wr(5'h08, 32'h40);
    check(irq == 0, "R10 hbusy cleared", 32'(irq), 0);
    rd(5'h08, v); check(v == 0, "R10 status zero", v, 0);

    // R11 release gated by busy
    wr(5'h10, 32'h80);
    check(in_release == 0, "R11 no release while busy", 32'(in_release), 0);
    wr(5'h10, 32'h80);
    check(in_release == 1, "R11 release on busy clear", 32'(in_release), 1);
    idle();
    check(in_release == 0, "R11 release one cycle", 32'(in_release), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule